// File: doc/BRIEF.md
# Video Raster Timing Aligner with External Sync

This block keeps the raster position for a pixel-clocked video encoder. In slave mode it takes horizontal and vertical sync from pins. It aligns a horizontal pixel counter to the falling edge of the horizontal sync, with a programmable pixel offset. It counts lines and follows the colour field sequence, and it decodes blanking and burst-gate windows from the aligned counters. In master mode the same counters run freely, and the block drives horizontal sync, vertical sync and the field flag itself.

Two line standards are supported, chosen by `pal_sel`. The 525-line standard has fields of 263 and 262 lines and a four-field colour sequence. The 625-line standard has fields of 313 and 312 lines and an eight-field sequence. Half-line fields are not handled. A field's length tells whether it was the long or the short field of a frame. A field start that arrives after an unexpected number of lines resynchronises the sequence and sets a sticky error flag.

The sync pins are turned around safely. The master selection is only taken while pin-slave mode is on. This means a controller has to enter slave mode, change the master selection, and then leave slave mode. The pins are therefore never driven while the block is also treating them as inputs.

Top module: `vid_sync_aligner`

## Requirements
- R1: After reset, `h_cnt`, `line_cnt`, `field_seq`, `field_err` and `sync_oe` are 0, and `hs_out` and `vs_out` are 1.
- R2: In slave mode (`slave_hv_en`=1), a falling edge on `hs_in` loads `h_cnt` with REF two clock edges after the pin changes. REF is the line length minus `h_offset`; REF is 0 when `h_offset` is 0 or not below the line length. `h_cnt` then counts up by one per clock and wraps to 0 after line length minus 1, so it reaches 0 exactly `h_offset` clocks after the load.
- R3: In slave mode, every `hs_in` falling edge advances `line_cnt` by one. A field start resets `line_cnt` to 0. A field start needs `vs_in` and `hs_in` to fall in the same sample; a `vs_in` fall at any other time has no effect.
- R4: Even `field_seq` values expect a long field (263 lines, or 313 with `pal_sel`=1). Odd values expect a short field (one line fewer). When a field start ends a field of the expected length, `field_seq` advances modulo 4 (`pal_sel`=0) or modulo 8 (`pal_sel`=1). `field_out` equals bit 0 of `field_seq`.
- R5: The first field start after reset sets `field_seq` to 0 and reports no error. A later field start that ends a field of unexpected length sets `field_err`, which stays at 1 until reset. It also reloads `field_seq`: to 1 if the ended field had the long length, otherwise to 0.
- R6: `master_en` is captured only on clocks where `slave_hv_en`=1. `sync_oe` is the captured value while `slave_hv_en`=0, and 0 while `slave_hv_en`=1.
- R7: With `slave_hv_en`=0, `h_cnt` runs freely. `line_cnt` advances on the clock where `h_cnt` enters REF. At the end of a field of the expected length, `line_cnt` returns to 0 and `field_seq` advances as in R4.
- R8: While `sync_oe`=1, `hs_out` is low for HS_W pixels starting at `h_cnt`=REF. `vs_out` is low while `line_cnt` is below VS_LINES, so its falling edge coincides with an `hs_out` falling edge. While `sync_oe`=0, both outputs are held at 1.
- R9: `blank` is 1 when `h_cnt` is at or above the active width of the selected standard, or when `line_cnt` is below that standard's vertical blanking count.
- R10: `burst_gate` is 1 when the pixel distance from REF to `h_cnt` lies in [BST, BST+BST_W) and `line_cnt` is at or above VS_LINES. BST is chosen per standard.
- R11: Line length, active width, field lengths, burst start and vertical blanking all follow `pal_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_sel | input | 1 | 0 = 525-line standard, 1 = 625-line standard |
| slave_hv_en | input | 1 | 1 = sync pins are inputs and set the timing |
| master_en | input | 1 | Master selection, captured only while slave_hv_en is 1 |
| h_offset | input | HW | Pixels from the HS falling edge to the first data pixel |
| hs_in | input | 1 | External horizontal sync, falling edge is the reference |
| vs_in | input | 1 | External vertical sync, active low |
| hs_out | output | 1 | Generated horizontal sync, active low |
| vs_out | output | 1 | Generated vertical sync, active low |
| field_out | output | 1 | Field parity (bit 0 of field_seq) |
| sync_oe | output | 1 | Pad output enable for the sync pins |
| h_cnt | output | HW | Aligned horizontal pixel position |
| line_cnt | output | LW | Line within the current field |
| field_seq | output | 3 | Position in the colour field sequence |
| blank | output | 1 | Blanking window |
| burst_gate | output | 1 | Colour burst window |
| field_err | output | 1 | Sticky unexpected-field-length flag |

## Verification
The hardest states to reach from the ports are the field-sequence wrap and the resynchronisation after a field of the wrong length. Reaching them needs many whole lines of correctly aligned HS and VS edges. The bench therefore overrides the line and field lengths with small values and produces each field with a line-generating task. It then sends a short field in the middle of the sequence, an overlong field built with a misaligned VS pulse, and complete 4-field and 8-field cycles, and checks `field_seq` and `field_err` after each field start.

// File: rtl/vid_sync_aligner.sv
module vid_sync_aligner #(
  parameter int HW       = 10,
  parameter int LW       = 10,
  parameter int N_PPL    = 858,
  parameter int P_PPL    = 864,
  parameter int N_ACT    = 720,
  parameter int P_ACT    = 720,
  parameter int N_FLONG  = 263,
  parameter int P_FLONG  = 313,
  parameter int N_VBL    = 20,
  parameter int P_VBL    = 23,
  parameter int N_BST    = 76,
  parameter int P_BST    = 80,
  parameter int BST_W    = 34,
  parameter int HS_W     = 64,
  parameter int VS_LINES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pal_sel,
  input  logic          slave_hv_en,
  input  logic          master_en,
  input  logic [HW-1:0] h_offset,
  input  logic          hs_in,
  input  logic          vs_in,
  output logic          hs_out,
  output logic          vs_out,
  output logic          field_out,
  output logic          sync_oe,
  output logic [HW-1:0] h_cnt,
  output logic [LW-1:0] line_cnt,
  output logic [2:0]    field_seq,
  output logic          blank,
  output logic          burst_gate,
  output logic          field_err
);

  localparam logic [LW-1:0] LMAX = '1;

  logic          hs_s, hs_p, vs_s, vs_p;
  logic          synced, mst_q;
  logic [HW-1:0] ppl, act, bst, ref_pos, h_next, hdist;
  logic [LW-1:0] flong, fshort, exp_len, vbl, len;
  logic [2:0]    seq_inc;
  logic          hs_fall, vs_fall, fstart, line_tick, fend;

  assign ppl   = pal_sel ? HW'(P_PPL)   : HW'(N_PPL);
  assign act   = pal_sel ? HW'(P_ACT)   : HW'(N_ACT);
  assign bst   = pal_sel ? HW'(P_BST)   : HW'(N_BST);
  assign flong = pal_sel ? LW'(P_FLONG) : LW'(N_FLONG);
  assign vbl   = pal_sel ? LW'(P_VBL)   : LW'(N_VBL);
  assign fshort  = flong - LW'(1);
  assign exp_len = field_seq[0] ? fshort : flong;
  assign seq_inc = (field_seq + 3'd1) & (pal_sel ? 3'd7 : 3'd3);
  assign len     = line_cnt + LW'(1);

  assign ref_pos = (h_offset == '0 || h_offset >= ppl) ? '0 : ppl - h_offset;
  assign h_next  = (h_cnt >= ppl - HW'(1)) ? '0 : h_cnt + HW'(1);
  assign hdist   = (h_cnt >= ref_pos) ? h_cnt - ref_pos : h_cnt + ppl - ref_pos;

  assign hs_fall   = hs_p & ~hs_s;
  assign vs_fall   = vs_p & ~vs_s;
  assign fstart    = slave_hv_en & hs_fall & vs_fall;
  assign line_tick = slave_hv_en ? hs_fall : (h_next == ref_pos);
  assign fend      = ~slave_hv_en & line_tick & (line_cnt >= exp_len - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_s <= 1'b1; hs_p <= 1'b1; vs_s <= 1'b1; vs_p <= 1'b1;
    end else begin
      hs_s <= hs_in; hs_p <= hs_s; vs_s <= vs_in; vs_p <= vs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    h_cnt <= '0;
    else if (slave_hv_en && hs_fall) h_cnt <= ref_pos;
    else                           h_cnt <= h_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt  <= '0;
      field_seq <= '0;
      field_err <= 1'b0;
      synced    <= 1'b0;
    end else if (fstart) begin
      line_cnt <= '0;
      if (!synced) begin
        synced    <= 1'b1;
        field_seq <= '0;
      end else if (len == exp_len) begin
        field_seq <= seq_inc;
      end else begin
        field_err <= 1'b1;
        field_seq <= (len == flong) ? 3'd1 : 3'd0;
      end
    end else if (fend) begin
      line_cnt  <= '0;
      field_seq <= seq_inc;
    end else if (line_tick && line_cnt != LMAX) begin
      line_cnt <= line_cnt + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mst_q <= 1'b0;
    else if (slave_hv_en) mst_q <= master_en;
  end

  assign sync_oe    = mst_q & ~slave_hv_en;
  assign hs_out     = ~(sync_oe & (hdist < HW'(HS_W)));
  assign vs_out     = ~(sync_oe & (line_cnt < LW'(VS_LINES)));
  assign field_out  = field_seq[0];
  assign blank      = (h_cnt >= act) | (line_cnt < vbl);
  assign burst_gate = (hdist >= bst) & (hdist < bst + HW'(BST_W)) &
                      (line_cnt >= LW'(VS_LINES));

endmodule

module vid_sync_aligner_chk #(
  parameter int HW    = 10,
  parameter int N_PPL = 858,
  parameter int P_PPL = 864
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pal_sel,
  input logic          slave_hv_en,
  input logic [HW-1:0] h_offset,
  input logic          hs_in,
  input logic          sync_oe,
  input logic          hs_out,
  input logic          vs_out,
  input logic [HW-1:0] h_cnt,
  input logic          field_err
);

  logic [1:0] pv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pv <= 2'd0;
    else if (pv != 2'd3) pv <= pv + 2'd1;
  end

  function automatic logic [HW-1:0] exp_ref(input logic pal, input logic [HW-1:0] off);
    logic [HW-1:0] l;
    l = pal ? HW'(P_PPL) : HW'(N_PPL);
    return (off == '0 || off >= l) ? '0 : l - off;
  endfunction

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_oe |-> !slave_hv_en); // R6

  AST_OE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 2'd0 && !slave_hv_en && !$past(slave_hv_en)) |-> $stable(sync_oe)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 2'd0 && $past(field_err)) |-> field_err); // R5

  AST_VS_ON_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 2'd0 && sync_oe && $past(sync_oe) && $stable(h_offset) && $stable(pal_sel)
     && $fell(vs_out)) |-> $fell(hs_out)); // R8

  AST_HS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (pv == 2'd3 && $past(slave_hv_en) && $past(hs_in, 3) && !$past(hs_in, 2))
    |-> h_cnt == exp_ref($past(pal_sel), $past(h_offset))); // R2

endmodule

bind vid_sync_aligner vid_sync_aligner_chk #(.HW(HW), .N_PPL(N_PPL), .P_PPL(P_PPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .slave_hv_en(slave_hv_en),
  .h_offset(h_offset), .hs_in(hs_in), .sync_oe(sync_oe), .hs_out(hs_out),
  .vs_out(vs_out), .h_cnt(h_cnt), .field_err(field_err)
);

// File: tb/vid_sync_aligner_tb.sv
module vid_sync_aligner_tb;
  localparam int CLK_NS = 10;
  localparam int NPPL = 40, PPL = 48, NACT = 28, PACT = 34;
  localparam int NFL = 9, PFL = 11, NVBL = 3, PVBL = 4;
  localparam int NBST = 6, PBST = 7, BSTW = 4, HSW = 5, VSL = 2;

  // pal, offset, extra clocks after load, expected h_cnt
  localparam int VEC[8][4] = '{
    '{0, 0, 0, 0}, '{0, 5, 0, 35}, '{0, 5, 5, 0}, '{0, 5, 7, 2},
    '{1, 10, 0, 38}, '{1, 10, 12, 2}, '{1, 0, 50, 2}, '{0, 39, 0, 1}
  };

  logic clk = 0, rst_n = 0;
  logic pal_sel = 0, slave_hv_en = 0, master_en = 0, hs_in = 1, vs_in = 1;
  logic [9:0] h_offset = '0;
  logic hs_out, vs_out, field_out, sync_oe, blank, burst_gate, field_err;
  logic [9:0] h_cnt, line_cnt;
  logic [2:0] field_seq;
  int nchk = 0, nerr = 0;

  always #(CLK_NS/2) clk = ~clk;

  vid_sync_aligner #(
    .N_PPL(NPPL), .P_PPL(PPL), .N_ACT(NACT), .P_ACT(PACT), .N_FLONG(NFL),
    .P_FLONG(PFL), .N_VBL(NVBL), .P_VBL(PVBL), .N_BST(NBST), .P_BST(PBST),
    .BST_W(BSTW), .HS_W(HSW), .VS_LINES(VSL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .slave_hv_en(slave_hv_en),
    .master_en(master_en), .h_offset(h_offset), .hs_in(hs_in), .vs_in(vs_in),
    .hs_out(hs_out), .vs_out(vs_out), .field_out(field_out), .sync_oe(sync_oe),
    .h_cnt(h_cnt), .line_cnt(line_cnt), .field_seq(field_seq), .blank(blank),
    .burst_gate(burst_gate), .field_err(field_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; hs_in = 1; vs_in = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_line(input bit vs_al, input bit vs_mid);
    int l;
    l = pal_sel ? PPL : NPPL;
    hs_in = 0; vs_in = vs_al ? 1'b0 : 1'b1;
    repeat (HSW) @(negedge clk);
    hs_in = 1;
    if (vs_mid) begin
      repeat (5) @(negedge clk); vs_in = 0;
      repeat (3) @(negedge clk); vs_in = 1;
      repeat (l - HSW - 8) @(negedge clk);
    end else begin
      repeat (l - HSW) @(negedge clk);
    end
  endtask

  task automatic send_field(input int n);
    send_line(1, 0);
    for (int i = 1; i < n; i++) send_line(0, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 h_cnt", h_cnt, 0);       chk("R1 line_cnt", line_cnt, 0);
    chk("R1 field_seq", field_seq, 0); chk("R1 field_err", field_err, 0);
    chk("R1 sync_oe", sync_oe, 0);   chk("R1 hs_out", hs_out, 1);
    chk("R1 vs_out", vs_out, 1);

    // R2 / R11 alignment vectors
    slave_hv_en = 1;
    for (int v = 0; v < 8; v++) begin
      pal_sel = VEC[v][0][0]; h_offset = 10'(VEC[v][1]); hs_in = 1;
      repeat (3) @(negedge clk);
      hs_in = 0;
      repeat (2 + VEC[v][2]) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2 R11 vec%0d h_cnt", v), h_cnt, VEC[v][3]);
      hs_in = 1;
    end

    // R3 R4 R5: 525-line field sequence
    pal_sel = 0; h_offset = '0; slave_hv_en = 1;
    do_reset();
    send_field(NFL);
    chk("R5 first sync seq", field_seq, 0); chk("R5 first sync err", field_err, 0);
    chk("R3 line count", line_cnt, NFL - 1);
    send_field(NFL - 1); chk("R4 seq1", field_seq, 1); chk("R4 field_out", field_out, 1);
    send_field(NFL);     chk("R4 seq2", field_seq, 2);
    send_field(NFL - 1); chk("R4 seq3", field_seq, 3);
    send_field(NFL);     chk("R4 wrap mod4", field_seq, 0);
    send_field(5);       chk("R4 seq1 again", field_seq, 1); chk("R5 no err yet", field_err, 0);
    send_field(NFL);     chk("R5 short resync seq", field_seq, 0); chk("R5 err set", field_err, 1);
    send_field(NFL - 1); chk("R5 err sticky", field_err, 1); chk("R4 seq after resync", field_seq, 1);
    send_line(0, 1);
    chk("R3 misaligned vs ignored line", line_cnt, NFL - 1);
    chk("R3 misaligned vs ignored seq", field_seq, 1);
    send_field(NFL);     chk("R5 long resync seq", field_seq, 1); chk("R5 err still", field_err, 1);

    // R4 R11: 625-line eight-field sequence
    pal_sel = 1;
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      send_field((k % 2 == 1) ? PFL : PFL - 1);
      if (k == 8) begin
        chk("R4 R11 pal seq7", field_seq, 7); chk("R4 pal field_out", field_out, 1);
      end
    end
    chk("R4 R11 pal wrap mod8", field_seq, 0); chk("R4 pal no err", field_err, 0);

    // R7 R9 R10: free-running counters and windows
    pal_sel = 0; slave_hv_en = 0; master_en = 0; h_offset = '0;
    do_reset();
    for (int m = 0; m < NFL * NPPL; m++) begin
      int h, ln;
      if (m > 0) @(negedge clk);
      h = m % NPPL; ln = m / NPPL;
      chk("R7 h_cnt", h_cnt, h);
      chk("R7 line_cnt", line_cnt, ln);
      chk("R9 blank", blank, (h >= NACT || ln < NVBL) ? 1 : 0);
      chk("R10 burst", burst_gate, (h >= NBST && h < NBST + BSTW && ln >= VSL) ? 1 : 0);
    end
    @(negedge clk);
    chk("R7 field end line", line_cnt, 0); chk("R7 field advance", field_seq, 1);

    // R6 interlock, R8 master outputs
    do_reset();
    master_en = 1; repeat (2) @(negedge clk);
    chk("R6 ignored while not slave", sync_oe, 0);
    slave_hv_en = 1; @(negedge clk);
    chk("R6 off in slave", sync_oe, 0);
    slave_hv_en = 0; #1;
    chk("R6 master on", sync_oe, 1);
    master_en = 0; repeat (2) @(negedge clk);
    chk("R6 change ignored", sync_oe, 1);
    begin
      logic phs, pvs, f;
      int hsf, vsr, vsf, guard;
      phs = hs_out; pvs = vs_out; guard = 0;
      while (!(pvs && !vs_out) && guard < 2000) begin
        phs = hs_out; pvs = vs_out; @(negedge clk); guard++;
      end
      chk("R8 vs fall with hs fall", (phs && !hs_out) ? 1 : 0, 1);
      f = field_out; hsf = 0; vsr = 0; vsf = 0;
      phs = hs_out; pvs = vs_out;
      for (int i = 1; i <= 800 && vsf == 0; i++) begin
        @(negedge clk);
        if (hsf == 0 && phs && !hs_out) hsf = i;
        if (vsr == 0 && !pvs && vs_out) vsr = i;
        if (pvs && !vs_out) vsf = i;
        phs = hs_out; pvs = vs_out;
      end
      chk("R8 hs period", hsf, NPPL);
      chk("R8 vs width", vsr, VSL * NPPL);
      chk("R8 R7 field period", vsf, (f ? NFL - 1 : NFL) * NPPL);
      chk("R8 field_out toggles", field_out, f ? 0 : 1);
    end
    slave_hv_en = 1; @(negedge clk);
    chk("R8 outputs high when disabled", hs_out & vs_out, 1);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule